// File: doc/BRIEF.md
# Multi-Tap Feedback Delay Line

This block delays a stream of signed 16-bit audio samples inside an on-chip circular buffer whose depth is a power of two. Two read taps, an early one and a late one, each look back by their own whole number of sample frames. The late tap is also scaled by a feedback gain and added to the incoming sample before that sum is stored, so echoes repeat and decay. The output is the dry input at unity gain plus the sum of both taps scaled by a wet gain. All sums and products are rounded back to 16 bits and saturate instead of wrapping.

Software sets the two delay targets and the two gains through a small write-only register port. A new delay target is not applied at once. It waits until the input sample is zero or changes sign, and then the live delay glides toward it. Each frame moves the delay by a bounded step, always below one tenth of the current delay, so that the read pointer never jumps and the output does not click. Audio advances only on frames marked by a sample-valid strobe. Each frame gives one result one clock later.

Top module: `echo_delay_core`

## Requirements
- R1: After reset, out_vld and out_smp are 0, both taps sit at MIN_DLY, both gains are 0, and every buffer location counts as zero until it has been written after that reset (a tap with delay d reads 0 until at least d frames have been written).
- R2: out_vld is high in exactly the clock after each clock with in_vld high and low otherwise. out_smp changes only in the clock after an in_vld clock and holds between frames.
- R3: For a frame with input x, with e and l the early and late tap values, out_smp = sat(x + q(e + l, wet_gain)). A tap with live delay d returns the value stored d frames earlier.
- R4: The value stored for that frame is sat(x + q(l, fb_gain)), and the late tap later returns it, so echoes recirculate.
- R5: Register writes use cfg_we with cfg_addr: 0 sets the early delay target, 1 sets the late delay target (both unsigned sample counts), 2 sets the feedback gain and 3 sets the wet gain (both signed Q1.15, 32768 = 1.0).
- R6: A delay target below MIN_DLY becomes MIN_DLY, and one above DEPTH-1 becomes DEPTH-1 (1023 by default).
- R7: The stored feedback gain is clamped to the range -FB_CAP..+FB_CAP (22937 by default, just under 0.7 in Q1.15).
- R8: A written target stays pending until a frame whose input is 0 or whose sign bit differs from that of the previous frame's input. The previous input counts as non-negative right after reset. A newer write replaces a pending target.
- R9: On each frame the live delay moves toward the accepted goal in force before that frame, by the smaller of the remaining distance and cap = max(1, floor(d/16) + floor(d/32)). Here d is the live delay, so the step stays below 10% of d. The live delay does not change between frames.
- R10: q(a, g) = floor((a*g + 16384) / 32768), which rounds half up, saturated to the 16-bit range. Every sum saturates at -32768 and 32767.
- R11: The buffer holds 2^AW samples, and addresses wrap modulo the depth. Runs longer than the depth keep exact tap timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Sample-valid strobe, one frame per high clock |
| in_smp | input | 16 | Input sample, two's complement |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select (0 early delay, 1 late delay, 2 feedback gain, 3 wet gain) |
| cfg_wdata | input | 16 | Register write value |
| out_vld | output | 1 | Output strobe, one clock after in_vld |
| out_smp | output | 16 | Mixed output sample, two's complement |

## Verification
A live delay that is one sample off, a goal taken at the wrong frame, or a glide step of the wrong size changes which stored sample a tap returns. Under random audio this shows as a wrong out_smp in the next frame whose tap region holds nonzero data, usually within one or two frames. A wrong feedback gain or a stale buffer word gets into the stored data. It appears one delay length later, when the late tap reaches that location, and then repeats with each pass around the loop. A wrong write pointer or fill count shows once the run wraps the buffer or just after a reset in the middle of a run, when stale words would reach the output.

// File: rtl/edc_pkg.sv
package edc_pkg;

  localparam int SW   = 16;
  localparam int NTAP = 2;

  typedef logic signed [SW-1:0] smp_t;
  typedef logic        [15:0]   dly_t;

  // clip a wide signed value to the sample range
  function automatic smp_t sat_wide(input logic signed [33:0] v);
    if (v > 34'sd32767)  return smp_t'(16'sh7fff);
    if (v < -34'sd32768) return smp_t'(16'sh8000);
    return v[SW-1:0];
  endfunction

  function automatic smp_t add_sat(input smp_t a, input smp_t b);
    logic signed [33:0] s;
    s = 34'(a) + 34'(b);
    return sat_wide(s);
  endfunction

  // Q1.15 product, round half up, saturate
  function automatic smp_t scale_q15(input logic signed [SW:0] a, input smp_t g);
    logic signed [33:0] p;
    p = 34'(a) * 34'(g);
    p = p + 34'sd16384;
    p = p >>> 15;
    return sat_wide(p);
  endfunction

  function automatic smp_t clamp_gain(input smp_t g, input smp_t cap);
    if (g > cap)  return cap;
    if (g < -cap) return -cap;
    return g;
  endfunction

  // largest delay move allowed in one frame (about 9.4% of d)
  function automatic dly_t step_cap(input dly_t d);
    dly_t c;
    c = (d >> 4) + (d >> 5);
    if (c == '0) c = 16'd1;
    return c;
  endfunction

  function automatic dly_t glide(input dly_t cur, input dly_t tgt);
    dly_t cap;
    cap = step_cap(cur);
    if (tgt > cur) return ((tgt - cur) > cap) ? cur + cap : tgt;
    if (tgt < cur) return ((cur - tgt) > cap) ? cur - cap : tgt;
    return cur;
  endfunction

endpackage

// File: rtl/edc_ring.sv
module edc_ring
  import edc_pkg::*;
#(
  parameter int AW = 10
)(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  smp_t wr_data_i,
  input  dly_t dly_i [NTAP],
  output smp_t rd_o  [NTAP]
);

  localparam int            DEPTH = 1 << AW;
  localparam logic [AW:0]   FULL  = (AW+1)'(DEPTH);

  smp_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr_q;
  logic [AW:0]   fill_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else if (wr_en_i) begin
      wr_ptr_q <= wr_ptr_q + AW'(1);
      if (fill_q != FULL) fill_q <= fill_q + (AW+1)'(1);
    end
  end

  // one read port per tap; locations not yet written read as zero
  for (genvar t = 0; t < NTAP; t++) begin : g_rd
    logic [AW-1:0] raddr;
    logic          written;
    assign raddr   = wr_ptr_q - dly_i[t][AW-1:0];
    assign written = dly_t'(fill_q) >= dly_i[t];
    assign rd_o[t] = written ? mem[raddr] : '0;
  end

  // R11
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> wr_ptr_q == $past(wr_ptr_q) + AW'(1));

  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(wr_ptr_q));

  // R1
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);

endmodule

// File: rtl/edc_tap_ctl.sv
module edc_tap_ctl
  import edc_pkg::*;
#(
  parameter int AW      = 10,
  parameter int MIN_DLY = 64
)(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  dly_t set_val_i,
  input  logic frame_i,
  input  logic zc_i,
  output dly_t dly_o
);

  localparam dly_t DMIN = dly_t'(MIN_DLY);
  localparam dly_t DMAX = dly_t'((1 << AW) - 1);

  dly_t pend_q, goal_q, live_q, set_clamped;
  logic pend_v_q;
  logic accept;   // pending target adopted this frame

  always_comb begin
    if (set_val_i < DMIN)      set_clamped = DMIN;
    else if (set_val_i > DMAX) set_clamped = DMAX;
    else                       set_clamped = set_val_i;
  end

  assign accept = frame_i && zc_i && pend_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= DMIN;
      pend_v_q <= 1'b0;
      goal_q   <= DMIN;
      live_q   <= DMIN;
    end else begin
      if (set_i) begin
        pend_q   <= set_clamped;
        pend_v_q <= 1'b1;
      end else if (accept) begin
        pend_v_q <= 1'b0;
      end
      if (accept)  goal_q <= pend_q;
      if (frame_i) live_q <= glide(live_q, goal_q);
    end
  end

  assign dly_o = live_q;

  // R6
  dly_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q >= DMIN && live_q <= DMAX);

  // R9
  step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> ((live_q >= $past(live_q)) ? (live_q - $past(live_q))
                                           : ($past(live_q) - live_q)) <= step_cap($past(live_q)));

  // R9
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> $stable(live_q));

  // R8
  goal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(goal_q));

endmodule

// File: rtl/echo_delay_core.sv
module echo_delay_core
  import edc_pkg::*;
#(
  parameter int AW      = 10,
  parameter int MIN_DLY = 64,
  parameter int FB_CAP  = 22937
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic signed [15:0] in_smp,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [15:0]        cfg_wdata,
  output logic               out_vld,
  output logic signed [15:0] out_smp
);

  localparam smp_t FBC = 16'(FB_CAP);

  smp_t fb_gain_q, wet_gain_q;
  logic prev_neg_q;

  // named internal events
  logic               zc;        // input zero or sign change
  logic               fb_set;
  logic               wet_set;
  smp_t               fb_mix;    // value stored this frame
  smp_t               wet_mix;   // output for this frame
  logic signed [16:0] tap_sum;

  dly_t tap_dly [NTAP];
  smp_t tap_rd  [NTAP];

  assign zc      = (in_smp == '0) || (in_smp[15] != prev_neg_q);
  assign fb_set  = cfg_we && (cfg_addr == 2'd2);
  assign wet_set = cfg_we && (cfg_addr == 2'd3);

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    edc_tap_ctl #(.AW(AW), .MIN_DLY(MIN_DLY)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (cfg_we && (cfg_addr == 2'(t))),
      .set_val_i (cfg_wdata),
      .frame_i   (in_vld),
      .zc_i      (zc),
      .dly_o     (tap_dly[t])
    );
  end

  edc_ring #(.AW(AW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (in_vld),
    .wr_data_i (fb_mix),
    .dly_i     (tap_dly),
    .rd_o      (tap_rd)
  );

  assign tap_sum = 17'(tap_rd[0]) + 17'(tap_rd[1]);
  assign fb_mix  = add_sat(in_smp, scale_q15(17'(tap_rd[1]), fb_gain_q));
  assign wet_mix = add_sat(in_smp, scale_q15(tap_sum, wet_gain_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_smp    <= '0;
      fb_gain_q  <= '0;
      wet_gain_q <= '0;
      prev_neg_q <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_smp    <= wet_mix;
        prev_neg_q <= in_smp[15];
      end
      if (fb_set)  fb_gain_q  <= clamp_gain($signed(cfg_wdata), FBC);
      if (wet_set) wet_gain_q <= $signed(cfg_wdata);
    end
  end

  // R7
  fb_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_gain_q <= FBC && fb_gain_q >= -FBC);

  // R2
  out_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld && $stable(out_smp));

endmodule

// File: tb/echo_delay_core_test.sv
module echo_delay_core_test;

  localparam int CLK_PER = 10;
  localparam int AW      = 10;
  localparam int DEPTH   = 1 << AW;
  localparam int MIN_DLY = 64;
  localparam int FB_CAP  = 22937;
  localparam int HN      = 4096;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_vld = 1'b0;
  logic signed [15:0] in_smp = '0;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_addr = '0;
  logic [15:0]        cfg_wdata = '0;
  logic               out_vld;
  logic signed [15:0] out_smp;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  echo_delay_core #(.AW(AW), .MIN_DLY(MIN_DLY), .FB_CAP(FB_CAP)) uut (
    .clk, .rst_n, .in_vld, .in_smp, .cfg_we, .cfg_addr, .cfg_wdata, .out_vld, .out_smp
  );

  // reference model state
  int hist [HN];
  int n;
  int live [2];
  int goal [2];
  int pend [2];
  bit pv   [2];
  int fbg, wetg, prev, last_out;

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int qmul(int a, int g);
    longint p, q;
    p = longint'(a) * longint'(g) + 64'sd16384;
    if (p >= 0) q = p / 32768;
    else        q = -((-p + 32767) / 32768);
    return sat16(q);
  endfunction

  function automatic int as_signed16(int v);
    int w;
    w = v & 65535;
    return (w >= 32768) ? w - 65536 : w;
  endfunction

  function automatic int dclamp(int v);
    if (v < MIN_DLY)   return MIN_DLY;
    if (v > DEPTH - 1) return DEPTH - 1;
    return v;
  endfunction

  function automatic int tap(int d);
    return (n >= d) ? hist[(n - d) % HN] : 0;
  endfunction

  function automatic int next_live(int l, int g);
    int c;
    c = l / 16 + l / 32;
    if (c < 1) c = 1;
    if (g > l) return (g - l > c) ? l + c : g;
    if (g < l) return (l - g > c) ? l - c : g;
    return l;
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    n = 0; fbg = 0; wetg = 0; prev = 0; last_out = 0;
    for (int t = 0; t < 2; t++) begin
      live[t] = MIN_DLY; goal[t] = MIN_DLY; pend[t] = MIN_DLY; pv[t] = 1'b0;
    end
  endtask

  // enters and leaves at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R1 out_vld after reset", int'(out_vld), 0);
    check("R1 out_smp after reset", int'(out_smp), 0);
  endtask

  task automatic cfg(int a, int v);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 2) begin
      pend[a] = dclamp(v & 65535); pv[a] = 1'b1;
    end else if (a == 2) begin
      fbg = as_signed16(v);
      if (fbg > FB_CAP)  fbg = FB_CAP;
      if (fbg < -FB_CAP) fbg = -FB_CAP;
    end else begin
      wetg = as_signed16(v);
    end
  endtask

  task automatic frame(int x, string tag);
    int e, l, exp_out, wdat;
    bit zc;
    e = tap(live[0]);
    l = tap(live[1]);
    exp_out = sat16(longint'(x) + qmul(e + l, wetg));
    wdat    = sat16(longint'(x) + qmul(l, fbg));
    in_vld = 1'b1; in_smp = 16'(x);
    @(negedge clk);
    in_vld = 1'b0;
    check({tag, " out_smp"}, int'(out_smp), exp_out);
    check("R2 out_vld on frame", int'(out_vld), 1);
    last_out = exp_out;
    hist[n % HN] = wdat;
    n++;
    zc = (x == 0) || ((x < 0) != (prev < 0));
    for (int t = 0; t < 2; t++) begin
      live[t] = next_live(live[t], goal[t]);
      if (pv[t] && zc) begin goal[t] = pend[t]; pv[t] = 1'b0; end
    end
    prev = x;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check("R2 out_vld idle", int'(out_vld), 0);
      check("R2 out_smp hold", int'(out_smp), last_out);
    end
  endtask

  function automatic int rnd_smp();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    do_reset();

    // R3: impulse through both taps at the reset delay, buffer masked before
    cfg(3, 16384);                       // R5 wet gain 0.5
    frame(8000, "R3 impulse");
    for (int i = 0; i < 80; i++) frame(0, "R3 impulse tail");
    idle(2);

    // R7: feedback gain above the cap, both signs, decaying echoes (R4)
    cfg(2, 32767);
    frame(10000, "R7 positive cap");
    for (int i = 0; i < 300; i++) frame(0, "R4 R7 recirculation");
    cfg(2, 16'h8000);
    frame(-12000, "R7 negative cap");
    for (int i = 0; i < 200; i++) frame(0, "R4 R7 recirculation");

    // R6: targets outside the legal range, glide under random audio (R9)
    cfg(2, 9000);
    cfg(0, 5);
    cfg(1, 5000);
    for (int i = 0; i < 400; i++) frame(rnd_smp(), "R6 R9 clamp glide");

    // R8: target stays pending while input keeps its sign
    frame(300, "R8 setup");
    cfg(1, 200);
    cfg(0, 700);
    for (int i = 0; i < 30; i++) frame(1 + int'($urandom_range(0, 999)), "R8 pending");
    cfg(1, 150);                          // replaces the pending value
    for (int i = 0; i < 10; i++) frame(1 + int'($urandom_range(0, 999)), "R8 replaced");
    frame(-500, "R8 sign change");
    for (int i = 0; i < 40; i++) frame(1 + int'($urandom_range(0, 999)), "R9 glide steps");
    idle(3);

    // R10: full-scale saturation and rounding
    cfg(3, 32767);
    cfg(2, 32767);
    for (int i = 0; i < 300; i++) begin
      int x;
      x = ($urandom_range(0, 1) == 1) ? 32767 - int'($urandom_range(0, 3))
                                      : -32768 + int'($urandom_range(0, 3));
      frame(x, "R10 saturation");
    end
    cfg(3, 16'hC000);                     // R5 negative wet gain -0.5
    cfg(2, 1);
    for (int i = 0; i < 100; i++) frame(int'($urandom_range(0, 7)) - 4, "R10 rounding");

    // R11: long random run past several buffer wraps, random settings
    for (int blk = 0; blk < 12; blk++) begin
      cfg(0, int'($urandom_range(0, 1200)));
      cfg(1, int'($urandom_range(0, 1200)));
      cfg(2, int'($urandom_range(0, 65535)));
      cfg(3, int'($urandom_range(0, 65535)));
      for (int i = 0; i < 250; i++) begin
        frame(rnd_smp(), "R11 R3 wrap run");
        if ($urandom_range(0, 7) == 0) idle(1);
      end
    end

    // R1: reset in mid-run, stale buffer words must read as zero
    do_reset();
    cfg(3, 32767);
    cfg(2, 20000);
    for (int i = 0; i < 150; i++) frame(rnd_smp(), "R1 stale masked");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule